// File: doc/BRIEF.md
# Four-Lane Register Renamer

This block sits between instruction decode and dispatch in an out-of-order core. Each cycle it takes a group of up to four decoded instructions. For every valid lane it gives a fresh physical destination tag and returns the tag that the destination register held before. It also returns the physical tags of both source registers and a state code for each source. The block keeps three structures: the architectural-to-physical map, a circular FIFO of free physical tags, and one busy bit per physical tag.

The block accepts a group as a whole or not at all. If free tags, reorder slots or issue-queue slots are too few for every valid lane, nothing is renamed and backpressure holds the group at the decode boundary. The block also takes part in two other operations. Commit hands back retired tags, and these can be reused in the same cycle. During rollback, squashed instructions are undone youngest first. A small controller has two states. `S_RUN` renames normally. `S_UNDO` is entered through transition `T_START_UNDO` on any cycle that carries restore requests. The controller stays in `S_UNDO` while restores continue (`T_KEEP_UNDO`) and returns to `S_RUN` through `T_END_UNDO` on the first cycle without them. `S_RUN` stays in `S_RUN` through `T_IDLE_RUN` when there are no restores.

Top module: `rename_core`

## Requirements
- R1: After reset, architectural register i maps to physical tag i for i = 0..31. The free FIFO holds tags 32..63 in ascending order, so the first tag handed out is 32. No busy bit is set.
- R2: A group is accepted (`grp_accept`=1) only when `grp_valid` is high, `flush` is low, renaming is not blocked, and the number of valid lanes is no more than each of these three: free tags, `rob_free` and `iq_free`. `grp_stall` equals `grp_valid` and not `grp_accept`. A refused group changes no state.
- R3: Tags released by commit in a cycle can be handed to lanes renamed in that same cycle. They are used after every tag already in the FIFO.
- R4: Released tags join the FIFO in lane order, lowest lane first, skipping lanes that are not valid. Valid rename lanes take tags from the head of the FIFO in lane order, skipping lanes that are not valid.
- R5: A restore request with lane 0 as the youngest instruction writes the old tag back into the map for each lane from 0 upward, so the oldest instruction's old tag wins. It pushes each lane's new tag onto the FIFO in lane order and clears that tag's busy bit.
- R6: Source state code 2'b01 means the value is in the register file (busy bit clear). 2'b10 means the tag is busy but appears on a forwarding port this cycle. 2'b00 means the value is not yet produced.
- R7: An accepted lane sets the busy bit of its new tag. A valid forwarding port clears the busy bit of its tag.
- R8: Inside a group, rename is sequential. A later lane whose source or destination names the destination of an earlier valid lane sees that lane's new tag as its source tag or old tag, and that source has state 2'b00.
- R9: Renaming is blocked in any cycle that carries restore requests and in the cycle after the last one (state `S_UNDO`).
- R10: With `flush` high, the pending group is dropped. Both `grp_accept` and `grp_stall` are low and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | A decoded group is present |
| lane_vld | input | LANES | Valid bit per lane |
| dst_arch | input | LANES*AW | Destination register per lane |
| srca_arch | input | LANES*AW | First source register per lane |
| srcb_arch | input | LANES*AW | Second source register per lane |
| flush | input | 1 | Drop the pending group |
| rob_free | input | SW | Free reorder slots |
| iq_free | input | SW | Free issue-queue slots |
| fwd_vld | input | LANES | Forwarding port valid |
| fwd_tag | input | LANES*TW | Forwarded result tag |
| rel_vld | input | LANES | Commit release valid, lane 0 oldest |
| rel_tag | input | LANES*TW | Released tag |
| rb_vld | input | LANES | Restore request valid, lane 0 youngest |
| rb_arch | input | LANES*AW | Destination register to restore |
| rb_old | input | LANES*TW | Tag to write back into the map |
| rb_new | input | LANES*TW | Tag to return to the FIFO |
| grp_accept | output | 1 | Group renamed this cycle |
| grp_stall | output | 1 | Backpressure to decode |
| new_tag | output | LANES*TW | Allocated destination tag |
| old_tag | output | LANES*TW | Previous destination mapping |
| srca_tag | output | LANES*TW | First source tag |
| srcb_tag | output | LANES*TW | Second source tag |
| srca_st | output | LANES*2 | First source state code |
| srcb_st | output | LANES*2 | Second source state code |

## Verification
Accept, stall, the tags and the source states all depend only on the present inputs and on stored state. They are therefore due in the same cycle as the stimulus. The bench drives the inputs just after a falling edge and compares these outputs one time unit later, within the same low phase. Any change to the map, the FIFO, the busy bits or the controller state takes effect at the next rising edge. Each such change is judged through the outputs of the next group, which the behavioural model predicts after it has applied the same edge. The refusal cycles around a restore are checked in the restore cycle itself and in the cycle after it.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [1:0] {
        SRC_WAIT = 2'b00,
        SRC_FILE = 2'b01,
        SRC_FWD  = 2'b10
    } src_state_e;

    typedef enum logic {
        S_RUN  = 1'b0,
        S_UNDO = 1'b1
    } rn_mode_e;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
    parameter int PHYS  = 64,
    parameter int ARCH  = 32,
    parameter int LANES = 4,
    localparam int TW = $clog2(PHYS),
    localparam int CW = $clog2(LANES + 1),
    localparam int IW = $clog2(LANES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            push_vld,
    input  logic [LANES-1:0][TW-1:0]    push_tag,
    input  logic [CW-1:0]               pop_cnt,
    output logic [TW:0]                 avail,
    output logic [LANES-1:0][TW-1:0]    pop_tag
);
    logic [PHYS-1:0][TW-1:0] mem_q;
    logic [TW-1:0]           head_q, tail_q;
    logic [TW:0]             cnt_q;
    logic [LANES-1:0][TW-1:0] cmp_tag;
    int                      push_n;

    // compact pushes so they join the FIFO in lane order
    always_comb begin
        cmp_tag = '0;
        push_n  = 0;
        for (int j = 0; j < LANES; j++) begin
            if (push_vld[j]) begin
                cmp_tag[IW'(push_n)] = push_tag[j];
                push_n = push_n + 1;
            end
        end
    end

    // pops see stored entries first, then this cycle's pushes
    always_comb begin
        avail = cnt_q + (TW+1)'(push_n);
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(cnt_q))
                pop_tag[k] = mem_q[head_q + TW'(k)];
            else
                pop_tag[k] = cmp_tag[IW'(k - int'(cnt_q))];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS; i++) mem_q[i] <= TW'(ARCH + i);
            head_q <= '0;
            tail_q <= TW'(PHYS - ARCH);
            cnt_q  <= (TW+1)'(PHYS - ARCH);
        end else begin
            for (int j = 0; j < LANES; j++) begin
                if (j < push_n) mem_q[tail_q + TW'(j)] <= cmp_tag[j];
            end
            tail_q <= tail_q + TW'(push_n);
            head_q <= head_q + TW'(pop_cnt);
            cnt_q  <= cnt_q + (TW+1)'(push_n) - (TW+1)'(pop_cnt);
        end
    end

    a_r3_pop_covered: assert property (@(posedge clk) disable iff (!rst_n)
        (TW+1)'(pop_cnt) <= avail);
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= PHYS);
endmodule

// File: rtl/rn_map.sv
module rn_map #(
    parameter int ARCH  = 32,
    parameter int PHYS  = 64,
    parameter int LANES = 4,
    localparam int AW = $clog2(ARCH),
    localparam int TW = $clog2(PHYS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit,
    input  logic [LANES-1:0]          lane_vld,
    input  logic [LANES-1:0][AW-1:0]  dst,
    input  logic [LANES-1:0][AW-1:0]  srca,
    input  logic [LANES-1:0][AW-1:0]  srcb,
    input  logic [LANES-1:0][TW-1:0]  new_tag,
    input  logic [LANES-1:0]          fwd_vld,
    input  logic [LANES-1:0][TW-1:0]  fwd_tag,
    input  logic [LANES-1:0]          rb_vld,
    input  logic [LANES-1:0][AW-1:0]  rb_arch,
    input  logic [LANES-1:0][TW-1:0]  rb_old,
    input  logic [LANES-1:0][TW-1:0]  rb_new,
    output logic [LANES-1:0][TW-1:0]  old_tag,
    output logic [LANES-1:0][TW-1:0]  a_tag,
    output logic [LANES-1:0][TW-1:0]  b_tag,
    output logic [LANES-1:0][1:0]     a_st,
    output logic [LANES-1:0][1:0]     b_st
);
    import rn_pkg::*;

    logic [ARCH-1:0][TW-1:0] map_q, map_t, map_d;
    logic [PHYS-1:0]         busy_q, busy_t, busy_d;

    function automatic logic [1:0] classify(input logic [TW-1:0] t,
                                            input logic [PHYS-1:0] bz,
                                            input logic [LANES-1:0] fv,
                                            input logic [LANES-1:0][TW-1:0] ft);
        logic hit;
        hit = 1'b0;
        for (int f = 0; f < LANES; f++) if (fv[f] && ft[f] == t) hit = 1'b1;
        if (!bz[t])  return SRC_FILE;
        else if (hit) return SRC_FWD;
        else          return SRC_WAIT;
    endfunction

    // sequential rename through the group
    always_comb begin
        map_t  = map_q;
        busy_t = busy_q;
        for (int i = 0; i < LANES; i++) begin
            a_tag[i]   = map_t[srca[i]];
            b_tag[i]   = map_t[srcb[i]];
            a_st[i]    = classify(a_tag[i], busy_t, fwd_vld, fwd_tag);
            b_st[i]    = classify(b_tag[i], busy_t, fwd_vld, fwd_tag);
            old_tag[i] = map_t[dst[i]];
            if (lane_vld[i]) begin
                map_t[dst[i]]      = new_tag[i];
                busy_t[new_tag[i]] = 1'b1;
            end
        end
    end

    always_comb begin
        map_d  = commit ? map_t : map_q;
        busy_d = busy_q;
        for (int f = 0; f < LANES; f++) if (fwd_vld[f]) busy_d[fwd_tag[f]] = 1'b0;
        for (int j = 0; j < LANES; j++) begin
            if (rb_vld[j]) begin
                map_d[rb_arch[j]] = rb_old[j];
                busy_d[rb_new[j]] = 1'b0;
            end
        end
        if (commit)
            for (int i = 0; i < LANES; i++) if (lane_vld[i]) busy_d[new_tag[i]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ARCH; r++) map_q[r] <= TW'(r);
            busy_q <= '0;
        end else begin
            map_q  <= map_d;
            busy_q <= busy_d;
        end
    end

    a_r7_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        commit && lane_vld[0] |=> busy_q[$past(new_tag[0])]);
    a_r7_fwd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_vld[0] && !commit |=> !busy_q[$past(fwd_tag[0])]);
    a_r5_oldest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rb_vld[LANES-1] |=> map_q[$past(rb_arch[LANES-1])] == $past(rb_old[LANES-1]));
endmodule

// File: rtl/rename_core.sv
module rename_core #(
    parameter int LANES  = 4,
    parameter int ARCH   = 32,
    parameter int PHYS   = 64,
    parameter int QDEPTH = 32,
    localparam int AW = $clog2(ARCH),
    localparam int TW = $clog2(PHYS),
    localparam int SW = $clog2(QDEPTH + 1),
    localparam int CW = $clog2(LANES + 1),
    localparam int IW = $clog2(LANES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 grp_valid,
    input  logic [LANES-1:0]     lane_vld,
    input  logic [LANES*AW-1:0]  dst_arch,
    input  logic [LANES*AW-1:0]  srca_arch,
    input  logic [LANES*AW-1:0]  srcb_arch,
    input  logic                 flush,
    input  logic [SW-1:0]        rob_free,
    input  logic [SW-1:0]        iq_free,
    input  logic [LANES-1:0]     fwd_vld,
    input  logic [LANES*TW-1:0]  fwd_tag,
    input  logic [LANES-1:0]     rel_vld,
    input  logic [LANES*TW-1:0]  rel_tag,
    input  logic [LANES-1:0]     rb_vld,
    input  logic [LANES*AW-1:0]  rb_arch,
    input  logic [LANES*TW-1:0]  rb_old,
    input  logic [LANES*TW-1:0]  rb_new,
    output logic                 grp_accept,
    output logic                 grp_stall,
    output logic [LANES*TW-1:0]  new_tag,
    output logic [LANES*TW-1:0]  old_tag,
    output logic [LANES*TW-1:0]  srca_tag,
    output logic [LANES*TW-1:0]  srcb_tag,
    output logic [LANES*2-1:0]   srca_st,
    output logic [LANES*2-1:0]   srcb_st
);
    import rn_pkg::*;

    rn_mode_e                  state_q, state_d;
    logic                      rb_any, blocked, ok;
    int                        need_n;
    logic [CW-1:0]             pop_cnt;
    logic [TW:0]               avail;
    logic [LANES-1:0][TW-1:0]  pop_tag, lane_new, push_tag;
    logic [LANES-1:0]          push_vld;

    assign rb_any   = |rb_vld;
    assign push_vld = rb_any ? rb_vld : rel_vld;
    assign push_tag = rb_any ? rb_new : rel_tag;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:  if (rb_any)  state_d = S_UNDO;
            S_UNDO: if (!rb_any) state_d = S_RUN;
        endcase
    end

    // outputs: group admission
    always_comb begin
        need_n = 0;
        for (int i = 0; i < LANES; i++) if (lane_vld[i]) need_n = need_n + 1;
        unique case (state_q)
            S_RUN:  blocked = rb_any;
            S_UNDO: blocked = 1'b1;
        endcase
        ok = grp_valid && !flush && !blocked
             && (need_n <= int'(avail))
             && (need_n <= int'(rob_free))
             && (need_n <= int'(iq_free));
        grp_accept = ok;
        grp_stall  = grp_valid && !flush && !ok;
        pop_cnt    = ok ? CW'(need_n) : '0;
    end

    // hand head-of-FIFO tags to valid lanes in order
    always_comb begin
        int s;
        s = 0;
        for (int i = 0; i < LANES; i++) begin
            lane_new[i] = pop_tag[IW'(s)];
            if (lane_vld[i]) s = s + 1;
        end
    end
    assign new_tag = lane_new;

    rn_freelist #(.PHYS(PHYS), .ARCH(ARCH), .LANES(LANES)) u_fl (
        .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_tag(push_tag),
        .pop_cnt(pop_cnt), .avail(avail), .pop_tag(pop_tag)
    );

    rn_map #(.ARCH(ARCH), .PHYS(PHYS), .LANES(LANES)) u_map (
        .clk(clk), .rst_n(rst_n), .commit(ok), .lane_vld(lane_vld),
        .dst(dst_arch), .srca(srca_arch), .srcb(srcb_arch), .new_tag(lane_new),
        .fwd_vld(fwd_vld), .fwd_tag(fwd_tag),
        .rb_vld(rb_vld), .rb_arch(rb_arch), .rb_old(rb_old), .rb_new(rb_new),
        .old_tag(old_tag), .a_tag(srca_tag), .b_tag(srcb_tag),
        .a_st(srca_st), .b_st(srcb_st)
    );

    a_r9_restore_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        rb_any |=> !grp_accept);
    a_r2_rob_short: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid && (need_n > int'(rob_free)) |-> !grp_accept);
    a_r10_flush_drop: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !grp_accept && !grp_stall);
    a_r4_no_mixed_push: assert property (@(posedge clk) disable iff (!rst_n)
        !(rb_any && |rel_vld));
endmodule

// File: tb/rename_core_tb.sv
module rename_core_tb;
    localparam int PERIOD = 10;
    localparam int L = 4, AW = 5, TW = 6, SW = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic grp_valid, flush;
    logic [L-1:0] lane_vld, fwd_vld, rel_vld, rb_vld;
    logic [L*AW-1:0] dst_arch, srca_arch, srcb_arch, rb_arch;
    logic [SW-1:0] rob_free, iq_free;
    logic [L*TW-1:0] fwd_tag, rel_tag, rb_old, rb_new;
    logic grp_accept, grp_stall;
    logic [L*TW-1:0] new_tag, old_tag, srca_tag, srcb_tag;
    logic [L*2-1:0] srca_st, srcb_st;

    int tests = 0, fails = 0;
    int m_map[32];
    bit m_busy[64];
    int m_fl[$];
    bit m_undo;
    int h_arch[$], h_old[$], h_new[$];

    always #(PERIOD/2) clk = ~clk;

    rename_core u_dut (.*);

    task automatic chk(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int stf(int t, bit bz[64]);
        if (!bz[t]) return 1;
        for (int f = 0; f < L; f++) if (fwd_vld[f] && int'(fwd_tag[f*TW +: TW]) == t) return 2;
        return 0;
    endfunction

    task automatic clr();
        grp_valid = 0; flush = 0; lane_vld = '0; fwd_vld = '0; rel_vld = '0; rb_vld = '0;
        dst_arch = '0; srca_arch = '0; srcb_arch = '0; rb_arch = '0;
        fwd_tag = '0; rel_tag = '0; rb_old = '0; rb_new = '0;
        rob_free = 6'd32; iq_free = 6'd32;
    endtask

    task automatic lane(int i, int d, int a, int b);
        grp_valid = 1; lane_vld[i] = 1'b1;
        dst_arch[i*AW +: AW] = AW'(d); srca_arch[i*AW +: AW] = AW'(a); srcb_arch[i*AW +: AW] = AW'(b);
    endtask

    task automatic rollback(int n);
        for (int j = 0; j < n; j++) begin
            rb_vld[j] = 1'b1;
            rb_arch[j*AW +: AW] = AW'(h_arch.pop_back());
            rb_old[j*TW +: TW]  = TW'(h_old.pop_back());
            rb_new[j*TW +: TW]  = TW'(h_new.pop_back());
        end
    endtask

    // compare this cycle's outputs with the model, then advance both
    task automatic step(string req);
        int pool[$]; int lmap[32]; bit lbusy[64]; int alloc[$];
        int need, k, a, b, d, nt; bit rbany, ok;
        #1;
        rbany = |rb_vld;
        need = $countones(lane_vld);
        pool = m_fl;
        if (!rbany) for (int j = 0; j < L; j++) if (rel_vld[j]) pool.push_back(int'(rel_tag[j*TW +: TW]));
        ok = grp_valid && !flush && !m_undo && !rbany && need <= pool.size()
             && need <= int'(rob_free) && need <= int'(iq_free);
        chk(req, "accept", int'(grp_accept), int'(ok));
        chk(req, "stall", int'(grp_stall), int'(grp_valid && !flush && !ok));
        lmap = m_map; lbusy = m_busy; k = 0;
        if (ok) for (int i = 0; i < L; i++) if (lane_vld[i]) begin
            d = int'(dst_arch[i*AW +: AW]); a = lmap[int'(srca_arch[i*AW +: AW])]; b = lmap[int'(srcb_arch[i*AW +: AW])];
            chk("R8", "srcA tag", int'(srca_tag[i*TW +: TW]), a);
            chk("R8", "srcB tag", int'(srcb_tag[i*TW +: TW]), b);
            chk("R6", "srcA state", int'(srca_st[i*2 +: 2]), stf(a, lbusy));
            chk("R6", "srcB state", int'(srcb_st[i*2 +: 2]), stf(b, lbusy));
            nt = pool[k]; k++;
            chk("R4", "new tag", int'(new_tag[i*TW +: TW]), nt);
            chk("R8", "old tag", int'(old_tag[i*TW +: TW]), lmap[d]);
            h_arch.push_back(d); h_old.push_back(lmap[d]); h_new.push_back(nt);
            lmap[d] = nt; lbusy[nt] = 1; alloc.push_back(nt);
        end
        if (rbany) begin
            for (int j = 0; j < L; j++) if (rb_vld[j]) begin
                m_map[int'(rb_arch[j*AW +: AW])] = int'(rb_old[j*TW +: TW]);
                m_fl.push_back(int'(rb_new[j*TW +: TW]));
                m_busy[int'(rb_new[j*TW +: TW])] = 0;
            end
        end else begin
            for (int j = 0; j < L; j++) if (rel_vld[j]) m_fl.push_back(int'(rel_tag[j*TW +: TW]));
        end
        for (int f = 0; f < L; f++) if (fwd_vld[f]) m_busy[int'(fwd_tag[f*TW +: TW])] = 0;
        if (ok) begin
            m_map = lmap;
            for (int x = 0; x < need; x++) void'(m_fl.pop_front());
            foreach (alloc[x]) m_busy[alloc[x]] = 1;
        end
        m_undo = rbany;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #(PERIOD*200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < 32; r++) m_map[r] = r;
        for (int p = 0; p < 64; p++) m_busy[p] = 0;
        for (int p = 32; p < 64; p++) m_fl.push_back(p);
        m_undo = 0;
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1", "reset accept", int'(grp_accept), 0);
        chk("R1", "reset stall", int'(grp_stall), 0);
        @(negedge clk);
        // R1: first group sees identity map and tag 32 first
        clr(); lane(0, 1, 2, 3);
        #1;
        chk("R1", "first new tag", int'(new_tag[TW-1:0]), 32);
        chk("R1", "first old tag", int'(old_tag[TW-1:0]), 1);
        step("R1");
        // R8: chained group with repeated destination
        clr(); lane(0, 4, 1, 1); lane(1, 5, 4, 2); lane(2, 4, 5, 4); lane(3, 6, 4, 0);
        step("R8");
        // R6/R7: forward tag 32 while reading x1, then value in file
        clr(); lane(0, 7, 1, 2); fwd_vld[0] = 1; fwd_tag[TW-1:0] = 6'd32;
        step("R6");
        clr(); lane(2, 8, 1, 7);
        step("R7");
        // R2: short reorder and issue slots, then R10 flush
        clr(); lane(0, 9, 8, 7); lane(1, 10, 9, 1); lane(3, 11, 10, 4); rob_free = 6'd2;
        step("R2");
        clr(); lane(0, 9, 8, 7); lane(1, 10, 9, 1); lane(3, 11, 10, 4); iq_free = 6'd1;
        step("R2");
        clr(); lane(0, 9, 8, 7); lane(1, 10, 9, 1); flush = 1;
        step("R10");
        clr(); lane(1, 9, 8, 7); lane(3, 10, 9, 1);
        step("R10");
        // R4: drain the free FIFO
        while (m_fl.size() >= 4) begin
            clr(); lane(0, 12, 2, 3); lane(1, 2, 12, 5); lane(2, 13, 2, 6); lane(3, 14, 13, 12);
            step("R4");
        end
        clr(); lane(0, 15, 1, 2); lane(1, 16, 15, 3); lane(2, 17, 4, 5); lane(3, 18, 17, 16);
        step("R2");
        // R3: two tags released this cycle make up the shortfall
        clr(); lane(0, 15, 1, 2); lane(1, 16, 15, 3); lane(2, 17, 4, 5); lane(3, 18, 17, 16);
        rel_vld[1] = 1; rel_tag[1*TW +: TW] = 6'd2; rel_vld[3] = 1; rel_tag[3*TW +: TW] = 6'd1;
        step("R3");
        // R5/R9: undo the youngest group while decode keeps offering
        clr(); rollback(4); lane(0, 20, 15, 16);
        step("R9");
        clr(); lane(0, 20, 15, 16);
        step("R9");
        clr(); lane(0, 20, 15, 16); lane(1, 21, 17, 18);
        step("R5");
        clr(); rollback(2);
        step("R5");
        clr(); rollback(3);
        step("R5");
        clr();
        step("R9");
        clr(); lane(0, 22, 12, 13); lane(1, 23, 14, 2); lane(2, 24, 4, 5); lane(3, 25, 20, 21);
        step("R5");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule